// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This controller lets a clocked system use an external asynchronous static RAM of 256K words by 16 bits. A requester presents one access at a time on a valid/ready handshake: an 18-bit word address, a write flag, 16 bits of write data and a two-bit lane mask. The controller turns each request into a sequence of active-low chip, output, write and byte-lane selects, with a shared address bus and a tri-state data bus, and holds every phase for a fixed number of clock cycles.

The number of wait cycles is the memory access time divided by the clock period, rounded up. With a 45 ns part and a 20 ns clock this gives 3 cycles. A read keeps the address and selects steady for that many cycles, samples the bus, and returns the word one cycle later with a one-cycle valid strobe. A write has a setup cycle, a write-enable pulse of the same wait length and a hold cycle. Only the lanes named in the mask are selected. A second write can be accepted in the hold cycle, so the chip stays selected between words.

Top module: `sram_lane_ctrl`

## Requirements
- R1: `req_ready` is high when no access is in progress and during the hold cycle of a write. It is low in every other cycle of an access. A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- R2: When no access is in progress, `mem_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_ub_n` and `mem_lb_n` are all high and the controller does not drive `mem_dq`.
- R3: A write with a non-zero mask holds `mem_we_n` low for exactly WAIT_CYC cycles. While `mem_we_n` is low, `mem_ce_n` is low and at least one byte select is low. `mem_oe_n` stays high for the whole write.
- R4: Mask bit 1 maps to `mem_ub_n` and data bits 15:8. Mask bit 0 maps to `mem_lb_n` and data bits 7:0. During the read phase and the write pulse, a lane's select is low only if its mask bit is 1, so a write changes only the enabled bytes of a word.
- R5: A read with a non-zero mask holds `mem_ce_n`, `mem_oe_n` and the enabled selects low for WAIT_CYC cycles and samples `mem_dq` at the end of the last one. `rsp_valid` is high for exactly one cycle, starting WAIT_CYC+1 cycles after the accepting edge. In `rsp_rdata`, a lane whose mask bit is 0 reads as zero.
- R6: The controller drives `mem_dq` only in the setup, pulse and hold cycles of a write, with the latched write data. It never drives the bus while `mem_oe_n` is low.
- R7: The address and write data are on the pins for one cycle before `mem_we_n` falls (the setup cycle) and for one cycle after it rises (the hold cycle). `mem_ce_n` is low and both byte selects are high in those two cycles.
- R8: A request with mask 2'b00 is accepted but drives no strobe and produces no response. `req_ready` stays high, and the stored word does not change.
- R9: A write taken during the hold cycle of an earlier write goes straight to its setup cycle, so `mem_ce_n` stays low between the two words. The address changes only after the hold cycle.
- R10: Reset is synchronous and active low. After a reset edge all strobes are high, `req_ready` is high and `rsp_valid` is low, even if the reset arrives in the middle of an access.
- R11: The wait count WAIT_CYC is the ceiling of ACCESS_NS divided by CLK_NS. The default values, 45 and 20, give 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The controller can take a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask: bit 1 is the upper byte, bit 0 is the lower byte |
| rsp_valid | output | 1 | One-cycle strobe for read data |
| rsp_rdata | output | 16 | Read data; disabled lanes are zero |
| mem_addr | output | 18 | Memory address bus |
| mem_dq | inout | 16 | Memory data bus, tri-state |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |

## Verification
Two events can fall in the same cycle: the hold cycle that closes one write, and the acceptance of the next request. The bench provokes this by keeping `req_valid` high across consecutive writes, and by sending a read straight after a write.

A behavioural model predicts, on every clock, the strobes, the readiness, the address and the bus value. The bench judges that cycle by two things. The address must stay on the old word through the hold cycle. The chip select must not rise between the two words.

Reads that come after partial-lane writes then show whether each earlier write changed only its own bytes.

// File: rtl/sram_lane_pkg.sv
// Package: shared sizes and the access phase encoding for the SRAM controller.
// Assumes a two-lane (upper/lower byte) memory word.
package sram_lane_pkg;
    localparam int LANES = 2;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_READ   = 3'd1,
        PH_WSETUP = 3'd2,
        PH_WPULSE = 3'd3,
        PH_WHOLD  = 3'd4
    } phase_t;
endpackage

// File: rtl/sram_wait_timer.sv
// Module: down-counter that times one access phase.
// A load starts a window of WAIT_CYC cycles. 'zero' is high in the last cycle of the window.
// Assumes WAIT_CYC >= 1.
module sram_wait_timer #(
    parameter int WAIT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic zero
);
    localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CNT_W-1:0] START = CNT_W'(WAIT_CYC - 1);

    logic [CNT_W-1:0] cnt;

    // Purpose: load the window length, then count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (load)          cnt <= START;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R11: a fresh load always opens a window longer than zero cycles unless WAIT_CYC is 1
    a_r11_load_start: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> (cnt == START));
endmodule

// File: rtl/sram_seq_fsm.sv
// Module: access sequencer. It latches one request and steps through the read phase,
// or through the write setup, pulse and hold phases, decoding the memory strobes.
// Assumes the timer 'zero' marks the last cycle of a loaded window.
module sram_seq_fsm
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              req_ready,
    input  logic              t_zero,
    output logic              t_load,
    output logic              cap_en,
    output logic [LANES-1:0]  cap_be,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] wdata_q,
    output logic              drv_en,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n
);
    phase_t            phase, phase_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [LANES-1:0]  be_q;
    logic              accept;
    logic              take;
    logic              lanes_on;

    assign req_ready = (phase == PH_IDLE) || (phase == PH_WHOLD);
    assign accept    = req_valid && req_ready;
    assign take      = accept && (req_be != '0);

    // Purpose: choose the next phase from the current phase, the handshake and the timer.
    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_IDLE, PH_WHOLD: begin
                if (take)        phase_nx = req_write ? PH_WSETUP : PH_READ;
                else             phase_nx = PH_IDLE;
            end
            PH_READ:   if (t_zero) phase_nx = PH_IDLE;
            PH_WSETUP:             phase_nx = PH_WPULSE;
            PH_WPULSE: if (t_zero) phase_nx = PH_WHOLD;
            default:               phase_nx = PH_IDLE;
        endcase
    end

    // Purpose: advance the phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

    // Purpose: latch address, data and mask when a non-empty request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            be_q   <= '0;
        end else if (take) begin
            addr_q <= req_addr;
            data_q <= req_wdata;
            be_q   <= req_be;
        end
    end

    assign t_load   = (take && !req_write) || (phase == PH_WSETUP);
    assign cap_en   = (phase == PH_READ) && t_zero;
    assign cap_be   = be_q;
    assign mem_addr = addr_q;
    assign wdata_q  = data_q;

    assign lanes_on = (phase == PH_READ) || (phase == PH_WPULSE);
    assign drv_en   = (phase == PH_WSETUP) || (phase == PH_WPULSE) || (phase == PH_WHOLD);
    assign mem_ce_n = (phase == PH_IDLE);
    assign mem_oe_n = (phase != PH_READ);
    assign mem_we_n = (phase != PH_WPULSE);
    assign mem_ub_n = !(lanes_on && be_q[1]);
    assign mem_lb_n = !(lanes_on && be_q[0]);

    // R6: the bus driver and the memory output enable are never active together
    a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> mem_oe_n);
    // R3: an internal write only while the chip is selected and a lane is selected
    a_r3_write_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && (!mem_ub_n || !mem_lb_n) && mem_oe_n));
    // R7: one setup cycle with bus driven and address held before write enable falls
    a_r7_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(drv_en) && !$past(mem_ce_n) && $stable(mem_addr)));
    // R7: one hold cycle with bus still driven and address stable after write enable rises
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (drv_en && !mem_ce_n && $stable(mem_addr) && $stable(wdata_q)));
    // R1: ready only when idle or closing a write
    a_r1_ready_phase: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_oe_n && mem_we_n));
endmodule

// File: rtl/sram_rd_capture.sv
// Module: read-data capture. It samples the data bus in the last read cycle,
// clears the lanes that were not requested and raises a one-cycle valid strobe.
// Assumes the bus is stable when cap_en is high.
module sram_rd_capture
    import sram_lane_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [LANES-1:0]  cap_be,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              mem_oe_n,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int LANE_W = DATA_W / LANES;

    logic [DATA_W-1:0] masked;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign masked[g*LANE_W +: LANE_W] = cap_be[g] ? bus_in[g*LANE_W +: LANE_W] : '0;
    end

    // Purpose: register the masked word and the one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= cap_en;
            if (cap_en) rsp_rdata <= masked;
        end
    end

    // R5: a response follows a cycle in which the output enable was active
    a_r5_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !$past(mem_oe_n));
    // R5: the strobe lasts a single cycle
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/sram_lane_ctrl.sv
// Module: top of the asynchronous SRAM byte-lane controller.
// It wires the sequencer, the wait timer and the read capture together and owns the
// tri-state data bus. It assumes one clock domain and an external memory that meets
// its access time within WAIT_CYC cycles.
module sram_lane_ctrl #(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int ACCESS_NS = 45,
    parameter int CLK_NS    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_dq,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n
);
    // R11: wait cycles are the rounded-up ratio of access time to clock period
    localparam int WAIT_RAW = (ACCESS_NS + CLK_NS - 1) / CLK_NS;
    localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;

    logic              t_zero;
    logic              t_load;
    logic              cap_en;
    logic [1:0]        cap_be;
    logic              drv_en;
    logic [DATA_W-1:0] wdata_q;

    sram_seq_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .req_ready (req_ready),
        .t_zero    (t_zero),
        .t_load    (t_load),
        .cap_en    (cap_en),
        .cap_be    (cap_be),
        .mem_addr  (mem_addr),
        .wdata_q   (wdata_q),
        .drv_en    (drv_en),
        .mem_ce_n  (mem_ce_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_ub_n  (mem_ub_n),
        .mem_lb_n  (mem_lb_n)
    );

    sram_wait_timer #(
        .WAIT_CYC (WAIT_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (t_load),
        .zero  (t_zero)
    );

    sram_rd_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .cap_be    (cap_be),
        .bus_in    (mem_dq),
        .mem_oe_n  (mem_oe_n),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // Purpose: drive the shared data bus only in write phases.
    assign mem_dq = drv_en ? wdata_q : {DATA_W{1'bz}};

    // R2: when deselected, no write or read strobe is active
    a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n && !drv_en));
endmodule

// File: tb/tb_sram_lane_ctrl.sv
// Bench: drives requests, models the memory from the pins, and compares the pins
// with a behavioural reference model on every clock.
module tb_sram_lane_ctrl;
    localparam int W = 3;   // ceil(45 / 20)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [17:0] mem_addr;
    wire  [15:0] dq;
    logic        ce_n, oe_n, we_n, ub_n, lb_n;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    sram_lane_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_dq(dq),
        .mem_ce_n(ce_n), .mem_oe_n(oe_n), .mem_we_n(we_n), .mem_ub_n(ub_n), .mem_lb_n(lb_n)
    );

    // Memory model, driven purely by the pins
    logic [15:0] mem [0:1023];
    logic [15:0] exp_mem [0:1023];
    logic        rd_on;
    assign rd_on = !ce_n && !oe_n && we_n;
    assign dq[15:8] = (rd_on && !ub_n) ? mem[mem_addr[9:0]][15:8] : 8'hzz;
    assign dq[7:0]  = (rd_on && !lb_n) ? mem[mem_addr[9:0]][7:0]  : 8'hzz;

    always @(posedge clk) begin
        if (!ce_n && !we_n) begin
            if (!ub_n) mem[mem_addr[9:0]][15:8] <= dq[15:8];
            if (!lb_n) mem[mem_addr[9:0]][7:0]  <= dq[7:0];
        end
    end

    // Reference model: 0 idle, 1 read, 2 setup, 3 pulse, 4 hold
    int          m_ph = 0;
    int          m_cnt = 0;
    logic [17:0] m_addr = '0;
    logic [15:0] m_data = '0;
    logic [1:0]  m_be = '0;
    logic        m_rsp = 1'b0;
    logic [15:0] m_rdata = '0;
    logic        m_ready;
    assign m_ready = (m_ph == 0) || (m_ph == 4);

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_rsp = 1'b0; m_cnt = 0;
        end else begin
            m_rsp = 1'b0;
            case (m_ph)
                1: if (m_cnt == 1) begin
                       m_rsp = 1'b1;
                       m_rdata = {m_be[1] ? exp_mem[m_addr[9:0]][15:8] : 8'h00,
                                  m_be[0] ? exp_mem[m_addr[9:0]][7:0]  : 8'h00};
                       m_ph = 0;
                   end else m_cnt--;
                2: begin m_ph = 3; m_cnt = W; end
                3: if (m_cnt == 1) begin
                       if (m_be[1]) exp_mem[m_addr[9:0]][15:8] = m_data[15:8];
                       if (m_be[0]) exp_mem[m_addr[9:0]][7:0]  = m_data[7:0];
                       m_ph = 4;
                   end else m_cnt--;
                default: begin
                    if (req_valid && req_be != 2'b00) begin
                        m_addr = req_addr; m_data = req_wdata; m_be = req_be;
                        if (req_write) m_ph = 2;
                        else begin m_ph = 1; m_cnt = W; end
                    end else m_ph = 0;
                end
            endcase
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
        end
    endtask

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (cyc > 1) begin
            chk("R1", "req_ready", 32'(req_ready), 32'(m_ready));
            chk("R2", "ce_n", 32'(ce_n), 32'(m_ph == 0));
            chk("R5", "oe_n", 32'(oe_n), 32'(m_ph != 1));
            chk("R3", "we_n", 32'(we_n), 32'(m_ph != 3));
            chk("R4", "ub_n", 32'(ub_n), 32'(!((m_ph == 1 || m_ph == 3) && m_be[1])));
            chk("R4", "lb_n", 32'(lb_n), 32'(!((m_ph == 1 || m_ph == 3) && m_be[0])));
            chk("R5", "rsp_valid", 32'(rsp_valid), 32'(m_rsp));
            if (m_rsp) chk("R5", "rsp_rdata", 32'(rsp_rdata), 32'(m_rdata));
            if (m_ph != 0) chk("R9", "mem_addr", 32'(mem_addr), 32'(m_addr));
            if (m_ph >= 2) chk("R6", "dq driven", 32'(dq), 32'(m_data));
        end
    end

    task automatic issue(input logic w, input logic [17:0] a, input logic [15:0] d,
                         input logic [1:0] be);
        logic acc;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
        do begin
            #1 acc = req_ready;
            @(posedge clk);
        end while (!acc);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i] = 16'(i * 16'h0101 + 16'h1234);
            exp_mem[i] = 16'(i * 16'h0101 + 16'h1234);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;                                // R10: reset state compared above
        idle(2);
        issue(1'b1, 18'h00010, 16'hA1B2, 2'b11); idle(2);   // R3 full write
        issue(1'b0, 18'h00010, 16'h0000, 2'b11); idle(6);   // R5 read back
        issue(1'b1, 18'h00010, 16'hCC00, 2'b10); idle(2);   // R4 upper lane only
        issue(1'b0, 18'h00010, 16'h0000, 2'b11); idle(6);
        issue(1'b1, 18'h00010, 16'h00DD, 2'b01); idle(2);   // R4 lower lane only
        issue(1'b0, 18'h00010, 16'h0000, 2'b01); idle(6);   // R5 upper lane reads zero
        issue(1'b1, 18'h00010, 16'hFFFF, 2'b00); idle(2);   // R8 empty write
        issue(1'b0, 18'h00010, 16'h0000, 2'b00); idle(3);   // R8 empty read
        issue(1'b0, 18'h00010, 16'h0000, 2'b11); idle(6);
        // R9 back-to-back writes with valid held high, then a read taken in hold
        issue(1'b1, 18'h00020, 16'h1111, 2'b11);
        issue(1'b1, 18'h00021, 16'h2222, 2'b10);
        issue(1'b1, 18'h00022, 16'h3333, 2'b01);
        issue(1'b0, 18'h00021, 16'h0000, 2'b11); idle(6);
        issue(1'b0, 18'h00022, 16'h0000, 2'b11); idle(6);
        issue(1'b0, 18'h00020, 16'h0000, 2'b10); idle(6);
        // R10 reset in the middle of a read
        issue(1'b0, 18'h00030, 16'h0000, 2'b11);
        @(negedge clk); req_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        idle(4);
        issue(1'b0, 18'h00030, 16'h0000, 2'b11); idle(6);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule